// File: doc/BRIEF.md
# Byte-Splittable General Register File

This block holds the general-purpose registers of a 16-bit processor core. Eight registers are reached through a 3-bit selector. Four of them are accumulator-style data registers, and each can be used as a full word or as two independent bytes. The other four serve as stack pointer, frame pointer and two index registers, and they are word-only. Two read ports can look at the file in the same cycle, and one write port updates it. Every port has a selector and a width bit.

A separate wide-result port exists for widening multiply and divide. In one clock cycle it stores the low result word in the accumulator and the high result word in the data register. Where this port and the normal write port aim at the same register, the wide port wins. Reads are combinational. Writes take effect at the next rising clock edge.

Top module: `gpr_bytefile`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets all eight registers to zero.
- R2: In word mode (`*_byte`=0), a write to one of the split registers (selectors 0 to 3) sets both halves at once. A word read of that register returns the high byte in bits 15:8 and the low byte in bits 7:0.
- R3: The word-mode selector encoding is 0=accumulator, 1=count, 2=data, 3=base, 4=stack pointer, 5=frame pointer, 6=source index, 7=destination index.
- R4: In byte mode (`*_byte`=1), selectors 0 to 3 choose the low byte of registers 0 to 3, and selectors 4 to 7 choose the high byte of registers 0 to 3. A byte read puts the byte in bits 7:0 and zeros in bits 15:8.
- R5: A byte write changes only the addressed half. The other half of the same register keeps its value.
- R6: Registers 4 to 7 can only be reached as words. No byte-mode access reads them or changes them.
- R7: A write appears on the read ports only after the next rising edge. Before that edge the reads return the old value, and with `wr_en`=0 nothing changes.
- R8: With `wide_en`=1, `wide_lo` is written to the accumulator (selector 0) and `wide_hi` is written to the data register (selector 2) at the same edge.
- R9: When `wide_en`=1, a normal write to the accumulator or the data register (any width or half) is dropped for that register. A normal write to any other register in the same cycle still takes effect.
- R10: The two read ports are independent. Each one returns the register that its own selector and width bit choose.
- R11: A byte write takes its value from `wr_data[7:0]`, and `wr_data[15:8]` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd0_sel | input | 3 | Read port 0 selector |
| rd0_byte | input | 1 | Read port 0 width, 1 = byte |
| rd0_data | output | 16 | Read port 0 data |
| rd1_sel | input | 3 | Read port 1 selector |
| rd1_byte | input | 1 | Read port 1 width, 1 = byte |
| rd1_data | output | 16 | Read port 1 data |
| wr_en | input | 1 | Normal write enable |
| wr_sel | input | 3 | Normal write selector |
| wr_byte | input | 1 | Normal write width, 1 = byte |
| wr_data | input | 16 | Normal write data |
| wide_en | input | 1 | Wide-result write enable |
| wide_lo | input | 16 | Low result word, goes to the accumulator |
| wide_hi | input | 16 | High result word, goes to the data register |

## Verification
The assertions expect every control input to be at a known 0 or 1 whenever `rst` is low, because the hold and override properties would mean nothing on unknown enables. They also expect reset to be applied at the very first edge. The bench meets both conditions. It raises `rst` at time zero, drives every input from a defined value, and changes inputs only on the falling clock edge, so they are stable at each rising edge. It also makes sure that a wide write lines up with normal writes both to the registers the wide port writes and to registers it does not write.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
   typedef enum logic [2:0] {
      SEL_ACC   = 3'd0,
      SEL_CNT   = 3'd1,
      SEL_DAT   = 3'd2,
      SEL_BAS   = 3'd3,
      SEL_STK   = 3'd4,
      SEL_FRM   = 3'd5,
      SEL_SRC   = 3'd6,
      SEL_DST   = 3'd7
   } gpr_sel_e;

   localparam int unsigned ACC_INDEX = 0;
   localparam int unsigned DAT_INDEX = 2;
endpackage

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned SEL_W  = 3,
   localparam int unsigned WORD_W = 2 * BYTE_W,
   localparam int unsigned N_HALF = 2 ** (SEL_W - 1)
) (
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic              wr_byte,
   input  logic [WORD_W-1:0] wr_data,
   output logic [N_HALF-1:0] lo_we,
   output logic [N_HALF-1:0] hi_we,
   output logic [N_HALF-1:0] word_we,
   output logic [BYTE_W-1:0] lo_d,
   output logic [BYTE_W-1:0] hi_d,
   output logic [WORD_W-1:0] word_d
);
   // Byte writes replicate the low data byte onto both half buses (R11)
   assign lo_d   = wr_data[BYTE_W-1:0];
   assign hi_d   = wr_byte ? wr_data[BYTE_W-1:0] : wr_data[WORD_W-1:BYTE_W];
   assign word_d = wr_data;

   for (genvar i = 0; i < N_HALF; i++) begin : g_dec
      logic hit_low_sel;
      logic hit_high_sel;
      assign hit_low_sel  = (wr_sel == SEL_W'(i));
      assign hit_high_sel = (wr_sel == SEL_W'(i + N_HALF));
      assign lo_we[i]   = wr_en && hit_low_sel;
      assign hi_we[i]   = wr_en && (wr_byte ? hit_high_sel : hit_low_sel);
      assign word_we[i] = wr_en && !wr_byte && hit_high_sel;
   end
endmodule

// File: rtl/gpr_split_reg.sv
module gpr_split_reg #(
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned WORD_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              lo_we,
   input  logic              hi_we,
   input  logic [BYTE_W-1:0] lo_d,
   input  logic [BYTE_W-1:0] hi_d,
   input  logic              ov_en,
   input  logic [WORD_W-1:0] ov_d,
   output logic [WORD_W-1:0] q
);
   logic [BYTE_W-1:0] lo_q;
   logic [BYTE_W-1:0] hi_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         lo_q <= '0;
         hi_q <= '0;
      end else if (ov_en) begin
         lo_q <= ov_d[BYTE_W-1:0];
         hi_q <= ov_d[WORD_W-1:BYTE_W];
      end else begin
         if (lo_we) lo_q <= lo_d;
         if (hi_we) hi_q <= hi_d;
      end
   end

   assign q = {hi_q, lo_q};

   a_r1_reset_clears: assert property (@(posedge clk) rst |=> (q == '0));
   a_r5_high_kept: assert property (@(posedge clk) disable iff (rst)
      (lo_we && !hi_we && !ov_en) |=> (q[WORD_W-1:BYTE_W] == $past(q[WORD_W-1:BYTE_W])));
   a_r5_low_kept: assert property (@(posedge clk) disable iff (rst)
      (hi_we && !lo_we && !ov_en) |=> (q[BYTE_W-1:0] == $past(q[BYTE_W-1:0])));
   a_r9_override_wins: assert property (@(posedge clk) disable iff (rst)
      ov_en |=> (q == $past(ov_d)));
endmodule

// File: rtl/gpr_word_reg.sv
module gpr_word_reg #(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [WORD_W-1:0] d,
   output logic [WORD_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (we) q <= d;
   end

   a_r6_word_hold: assert property (@(posedge clk) disable iff (rst)
      !we |=> $stable(q));
   a_r1_word_reset: assert property (@(posedge clk) rst |=> (q == '0));
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned SEL_W  = 3,
   localparam int unsigned WORD_W = 2 * BYTE_W,
   localparam int unsigned N_HALF = 2 ** (SEL_W - 1)
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [SEL_W-1:0]              sel,
   input  logic                          is_byte,
   input  logic [N_HALF-1:0][WORD_W-1:0] split_q,
   input  logic [N_HALF-1:0][WORD_W-1:0] word_q,
   output logic [WORD_W-1:0]             data
);
   logic [SEL_W-2:0]  idx;
   logic [WORD_W-1:0] pick_split;
   logic [BYTE_W-1:0] pick_byte;

   assign idx        = sel[SEL_W-2:0];
   assign pick_split = split_q[idx];

   always_comb begin
      pick_byte = sel[SEL_W-1] ? pick_split[WORD_W-1:BYTE_W] : pick_split[BYTE_W-1:0];
      if (is_byte)            data = {{BYTE_W{1'b0}}, pick_byte};
      else if (sel[SEL_W-1])  data = word_q[idx];
      else                    data = pick_split;
   end

   a_r4_byte_zero_ext: assert property (@(posedge clk) disable iff (rst)
      is_byte |-> (data[WORD_W-1:BYTE_W] == '0));
endmodule

// File: rtl/gpr_bytefile.sv
module gpr_bytefile
   import gpr_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned SEL_W  = 3,
   localparam int unsigned WORD_W = 2 * BYTE_W,
   localparam int unsigned N_HALF = 2 ** (SEL_W - 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [SEL_W-1:0]  rd0_sel,
   input  logic              rd0_byte,
   output logic [WORD_W-1:0] rd0_data,
   input  logic [SEL_W-1:0]  rd1_sel,
   input  logic              rd1_byte,
   output logic [WORD_W-1:0] rd1_data,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic              wr_byte,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              wide_en,
   input  logic [WORD_W-1:0] wide_lo,
   input  logic [WORD_W-1:0] wide_hi
);
   if (SEL_W < 3) begin : g_bad_sel
      $error("gpr_bytefile: SEL_W must be at least 3");
   end
   if (BYTE_W < 1) begin : g_bad_byte
      $error("gpr_bytefile: BYTE_W must be positive");
   end
   if (ACC_INDEX >= N_HALF || DAT_INDEX >= N_HALF || ACC_INDEX == DAT_INDEX) begin : g_bad_idx
      $error("gpr_bytefile: wide-result targets out of range");
   end

   logic [N_HALF-1:0]             lo_we, hi_we, word_we;
   logic [BYTE_W-1:0]             lo_d, hi_d;
   logic [WORD_W-1:0]             word_d;
   logic [N_HALF-1:0][WORD_W-1:0] split_q;
   logic [N_HALF-1:0][WORD_W-1:0] word_q;

   gpr_wr_decode #(.BYTE_W(BYTE_W), .SEL_W(SEL_W)) i_dec (
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_byte(wr_byte), .wr_data(wr_data),
      .lo_we(lo_we), .hi_we(hi_we), .word_we(word_we),
      .lo_d(lo_d), .hi_d(hi_d), .word_d(word_d)
   );

   for (genvar i = 0; i < N_HALF; i++) begin : g_split
      logic              ov_en;
      logic [WORD_W-1:0] ov_d;
      if (i == ACC_INDEX) begin : g_acc
         assign ov_en = wide_en;
         assign ov_d  = wide_lo;
      end else if (i == DAT_INDEX) begin : g_dat
         assign ov_en = wide_en;
         assign ov_d  = wide_hi;
      end else begin : g_plain
         assign ov_en = 1'b0;
         assign ov_d  = '0;
      end
      gpr_split_reg #(.BYTE_W(BYTE_W)) i_reg (
         .clk(clk), .rst(rst), .lo_we(lo_we[i]), .hi_we(hi_we[i]),
         .lo_d(lo_d), .hi_d(hi_d), .ov_en(ov_en), .ov_d(ov_d), .q(split_q[i])
      );
   end

   for (genvar j = 0; j < N_HALF; j++) begin : g_word
      gpr_word_reg #(.WORD_W(WORD_W)) i_reg (
         .clk(clk), .rst(rst), .we(word_we[j]), .d(word_d), .q(word_q[j])
      );
   end

   gpr_read_port #(.BYTE_W(BYTE_W), .SEL_W(SEL_W)) i_rd0 (
      .clk(clk), .rst(rst), .sel(rd0_sel), .is_byte(rd0_byte),
      .split_q(split_q), .word_q(word_q), .data(rd0_data)
   );
   gpr_read_port #(.BYTE_W(BYTE_W), .SEL_W(SEL_W)) i_rd1 (
      .clk(clk), .rst(rst), .sel(rd1_sel), .is_byte(rd1_byte),
      .split_q(split_q), .word_q(word_q), .data(rd1_data)
   );

   a_r8_wide_pair: assert property (@(posedge clk) disable iff (rst)
      wide_en |=> (split_q[ACC_INDEX] == $past(wide_lo) && split_q[DAT_INDEX] == $past(wide_hi)));
   a_r7_idle_no_change: assert property (@(posedge clk) disable iff (rst)
      (!wr_en && !wide_en) |=> ($stable(split_q) && $stable(word_q)));
endmodule

// File: tb/test_gpr_bytefile.sv
module test_gpr_bytefile;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  rd0_sel = '0, rd1_sel = '0, wr_sel = '0;
   logic        rd0_byte = 1'b0, rd1_byte = 1'b0, wr_en = 1'b0, wr_byte = 1'b0, wide_en = 1'b0;
   logic [15:0] wr_data = '0, wide_lo = '0, wide_hi = '0;
   logic [15:0] rd0_data, rd1_data;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   gpr_bytefile i_gpr_bytefile (
      .clk(clk), .rst(rst),
      .rd0_sel(rd0_sel), .rd0_byte(rd0_byte), .rd0_data(rd0_data),
      .rd1_sel(rd1_sel), .rd1_byte(rd1_byte), .rd1_data(rd1_data),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_byte(wr_byte), .wr_data(wr_data),
      .wide_en(wide_en), .wide_lo(wide_lo), .wide_hi(wide_hi)
   );

   typedef struct packed {
      logic        we;
      logic [2:0]  ws;
      logic        wb;
      logic [15:0] wd;
      logic        xe;
      logic [15:0] xl;
      logic [15:0] xh;
      logic [2:0]  s0;
      logic        b0;
      logic [2:0]  s1;
      logic        b1;
      logic [15:0] e0;
      logic [15:0] e1;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 3'd0, 1'b0, 16'h1234, 1'b0, 16'h0, 16'h0, 3'd0, 1'b0, 3'd4, 1'b1, 16'h1234, 16'h0012, 8'd2},  // R2
      '{1'b1, 3'd1, 1'b0, 16'hABCD, 1'b0, 16'h0, 16'h0, 3'd1, 1'b1, 3'd5, 1'b1, 16'h00CD, 16'h00AB, 8'd4},  // R4
      '{1'b1, 3'd2, 1'b1, 16'hFF77, 1'b0, 16'h0, 16'h0, 3'd2, 1'b0, 3'd2, 1'b1, 16'h0077, 16'h0077, 8'd11}, // R11
      '{1'b1, 3'd6, 1'b1, 16'h0055, 1'b0, 16'h0, 16'h0, 3'd2, 1'b0, 3'd0, 1'b0, 16'h5577, 16'h1234, 8'd5},  // R5
      '{1'b1, 3'd0, 1'b1, 16'h0099, 1'b0, 16'h0, 16'h0, 3'd0, 1'b0, 3'd4, 1'b1, 16'h1299, 16'h0012, 8'd5},  // R5
      '{1'b1, 3'd7, 1'b1, 16'h00EE, 1'b0, 16'h0, 16'h0, 3'd3, 1'b0, 3'd7, 1'b0, 16'hEE00, 16'h0000, 8'd6},  // R6
      '{1'b1, 3'd4, 1'b0, 16'h4444, 1'b0, 16'h0, 16'h0, 3'd4, 1'b0, 3'd4, 1'b1, 16'h4444, 16'h0012, 8'd3},  // R3
      '{1'b1, 3'd5, 1'b0, 16'h5555, 1'b0, 16'h0, 16'h0, 3'd5, 1'b0, 3'd6, 1'b0, 16'h5555, 16'h0000, 8'd3},  // R3
      '{1'b1, 3'd6, 1'b0, 16'h6666, 1'b0, 16'h0, 16'h0, 3'd6, 1'b0, 3'd7, 1'b0, 16'h6666, 16'h0000, 8'd10}, // R10
      '{1'b1, 3'd7, 1'b0, 16'h7777, 1'b0, 16'h0, 16'h0, 3'd7, 1'b0, 3'd4, 1'b0, 16'h7777, 16'h4444, 8'd10}, // R10
      '{1'b1, 3'd3, 1'b0, 16'h3333, 1'b1, 16'hAAAA, 16'hBBBB, 3'd0, 1'b0, 3'd2, 1'b0, 16'hAAAA, 16'hBBBB, 8'd8}, // R8
      '{1'b0, 3'd0, 1'b0, 16'h0000, 1'b0, 16'h0, 16'h0, 3'd3, 1'b0, 3'd1, 1'b0, 16'h3333, 16'hABCD, 8'd9},  // R9 other target kept
      '{1'b1, 3'd6, 1'b1, 16'h00FF, 1'b1, 16'h0101, 16'h0202, 3'd2, 1'b0, 3'd0, 1'b0, 16'h0202, 16'h0101, 8'd9}, // R9
      '{1'b1, 3'd0, 1'b0, 16'h9999, 1'b1, 16'h1111, 16'h2222, 3'd0, 1'b0, 3'd2, 1'b1, 16'h1111, 16'h0022, 8'd9}, // R9
      '{1'b0, 3'd0, 1'b0, 16'hFFFF, 1'b0, 16'h0, 16'h0, 3'd0, 1'b0, 3'd2, 1'b0, 16'h1111, 16'h2222, 8'd7}   // R7
   };

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      wr_en = 1'b0; wide_en = 1'b0; wr_byte = 1'b0; wr_sel = '0;
      wr_data = '0; wide_lo = '0; wide_hi = '0;
   endtask

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      for (int s = 0; s < 8; s++) begin
         rd0_sel = 3'(s); rd0_byte = 1'b0; rd1_sel = 3'(s); rd1_byte = 1'b1;
         #1;
         check($sformatf("R1 reset word sel %0d", s), rd0_data, 16'h0000);
         check($sformatf("R1 reset byte sel %0d", s), rd1_data, 16'h0000);
      end

      // table walk
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         wr_en = VECS[v].we; wr_sel = VECS[v].ws; wr_byte = VECS[v].wb; wr_data = VECS[v].wd;
         wide_en = VECS[v].xe; wide_lo = VECS[v].xl; wide_hi = VECS[v].xh;
         rd0_sel = VECS[v].s0; rd0_byte = VECS[v].b0;
         rd1_sel = VECS[v].s1; rd1_byte = VECS[v].b1;
         @(posedge clk);
         #2;
         check($sformatf("R%0d vector %0d port0", VECS[v].req, v), rd0_data, VECS[v].e0);
         check($sformatf("R%0d vector %0d port1", VECS[v].req, v), rd1_data, VECS[v].e1);
      end

      // R7: write not visible before the edge, visible after
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 3'd0; wr_byte = 1'b0; wr_data = 16'h5A5A; wide_en = 1'b0;
      rd0_sel = 3'd0; rd0_byte = 1'b0;
      #2;
      check("R7 before edge", rd0_data, 16'h1111);
      @(posedge clk);
      #2;
      check("R7 after edge", rd0_data, 16'h5A5A);

      // R6: byte write with selector 4 hits accumulator high half, not stack pointer
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 3'd4; wr_byte = 1'b1; wr_data = 16'h00C3;
      rd0_sel = 3'd4; rd0_byte = 1'b0; rd1_sel = 3'd0; rd1_byte = 1'b0;
      @(posedge clk);
      #2;
      check("R6 stack pointer untouched", rd0_data, 16'h4444);
      check("R6 accumulator high half written", rd1_data, 16'hC35A);

      // R1: reset again after use
      @(negedge clk);
      idle_inputs();
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      rd0_sel = 3'd7; rd0_byte = 1'b0; rd1_sel = 3'd0; rd1_byte = 1'b0;
      #1;
      check("R1 reset clears index", rd0_data, 16'h0000);
      check("R1 reset clears accumulator", rd1_data, 16'h0000);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule